// File: doc/BRIEF.md
# Transmit Packet Field Sequencer

This block assembles one outgoing radio packet as a stream of tagged items for a spreading stage further down. A single `start` pulse, given while the block is idle, captures the configuration. The block then walks through the packet fields and offers them one item per handshake. The fields come in this order: preamble units, two start-of-packet framing symbols, a length byte, payload bytes pulled from an upstream valid/ready source, and two CRC-16 bytes that the block computes itself.

Each item carries tags for the spreader:
- a field type;
- a flag that selects the framing code rather than the body code;
- the framing symbol length (32 or 64 chips);
- the body data mode.

The same body mode applies to every field after the framing symbols. The mode also decides which optional fields are allowed. Two modes always frame, one mode never frames, and one mode leaves framing to the configuration. A length field always follows framing.

A one-cycle `done` pulse marks the acceptance of the final item. The block refuses a new `start` until the packet in flight has finished.

Top module: `tx_pkt_seq`

## Requirements
- R1: After reset, `busy`, `done`, `out_valid` and `in_ready` are all 0.
- R2: Items leave in this order, with these `out_field` codes:
  - preamble = 1;
  - first framing symbol = 2;
  - second framing symbol = 3;
  - length = 4;
  - payload = 5;
  - CRC high byte = 6;
  - CRC low byte = 7.
  
  Fields that are disabled are skipped.
- R3: The preamble is `cfg_pre_units` items. Item j carries data j. A count of 0 emits no preamble.
- R4: Framing depends on `cfg_mode`:
  - modes 0 and 1 always emit both framing symbols;
  - mode 3 never emits them;
  - mode 2 emits them only when `cfg_frame_en` is 1.
  
  The framing symbols carry data 0 and 1, in that order.
- R5: The length byte is emitted whenever framing is emitted, or whenever `cfg_len_en` is 1. Its value is `cfg_pay_len`, the payload count, which does not include the CRC bytes.
- R6: Exactly `cfg_pay_len` payload bytes are taken through `in_valid`/`in_ready` and passed out in order. `in_ready` is high only during the payload field. A count of 0 emits no payload item but keeps the length byte and the CRC.
- R7: When `cfg_crc_en` is 1, two CRC bytes follow, high byte first. The CRC is polynomial 0x8005, taken MSB first over the payload bytes only, with no final inversion. The seed is 0 when `cfg_crc_zero_seed` is 1 and `cfg_crc_seed` otherwise. When `cfg_crc_en` is 0, no CRC item is emitted.
- R8: Item tags:
  - `out_code` is 1 only on framing symbols;
  - `out_long` equals `cfg_sym_long` on framing symbols and 0 elsewhere;
  - `out_rate` equals `cfg_mode` on every item.
- R9: While `out_valid` is high and `out_ready` is low on a non-payload item, that item holds still.
- R10: `busy` is high from the accepted `start` until `done`. `done` pulses high in the cycle after the final item is accepted, or in the cycle after `start` when no field is enabled. A `start` given while busy is ignored.
- R11: Configuration inputs are captured at the accepted `start`. Changes made to them during a packet have no effect on that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet when idle |
| cfg_mode | input | 2 | Body data mode 0..3 |
| cfg_frame_en | input | 1 | Framing request (mode 2 only) |
| cfg_len_en | input | 1 | Length field request |
| cfg_crc_en | input | 1 | Append CRC |
| cfg_crc_zero_seed | input | 1 | Use zero CRC seed |
| cfg_sym_long | input | 1 | Framing symbols use 64-chip code |
| cfg_pre_units | input | PRE_W | Preamble unit count |
| cfg_pay_len | input | 8 | Payload byte count |
| cfg_crc_seed | input | 16 | Programmable CRC seed |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte taken |
| out_data | output | 8 | Item data |
| out_field | output | 3 | Item field type |
| out_code | output | 1 | Framing code select |
| out_long | output | 1 | 64-chip framing symbol |
| out_rate | output | 2 | Body data mode tag |
| out_valid | output | 1 | Item valid |
| out_ready | input | 1 | Item accepted downstream |
| busy | output | 1 | Packet in progress |
| done | output | 1 | Packet complete pulse |

## Verification
The bench sweeps every combination of the following:
- all four modes;
- both framing, length and CRC enables;
- preamble counts 0, 2 and 15;
- payload lengths 0, 1 and 5.

This sweep separates the mode-forced framing cases from the configuration-driven ones. It also isolates the zero-length and fully empty packets, where only `done` shows that the packet is over.

Two things change from packet to packet:
- the CRC seed and the zero-seed choice, which separates the two seed sources;
- irregular stall patterns on both handshakes, which exercise holding and payload pacing.

Scrambling the configuration and re-pulsing `start` in mid-packet shows whether the captured settings stay fixed.

// File: rtl/tx_pkt_seq.sv
module tx_pkt_seq #(
  parameter int PRE_W = 4,
  parameter logic [15:0] CRC_POLY = 16'h8005
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_frame_en,
  input  logic             cfg_len_en,
  input  logic             cfg_crc_en,
  input  logic             cfg_crc_zero_seed,
  input  logic             cfg_sym_long,
  input  logic [PRE_W-1:0] cfg_pre_units,
  input  logic [7:0]       cfg_pay_len,
  input  logic [15:0]      cfg_crc_seed,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       out_data,
  output logic [2:0]       out_field,
  output logic             out_code,
  output logic             out_long,
  output logic [1:0]       out_rate,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             busy,
  output logic             done
);
  localparam logic [2:0] S_IDLE = 3'd0, S_PRE = 3'd1, S_FR1 = 3'd2, S_FR2 = 3'd3,
                         S_LEN = 3'd4, S_PAY = 3'd5, S_CRH = 3'd6, S_CRL = 3'd7;

  logic [2:0]       state;
  logic [7:0]       cnt;
  logic [15:0]      crc;
  logic [1:0]       mode_q;
  logic             frame_q, len_q, crc_q, long_q;
  logic [PRE_W-1:0] pre_q;
  logic [7:0]       plen_q;

  function automatic logic [2:0] follow(input logic [7:1] en, input logic [2:0] cur);
    follow = S_IDLE;
    for (int k = 7; k >= 1; k--)
      if (k > int'(cur) && en[k]) follow = 3'(k);
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = (r[15] ^ b[i]) ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction

  wire frame_in = (cfg_mode == 2'd0 || cfg_mode == 2'd1) ? 1'b1 :
                  (cfg_mode == 2'd3) ? 1'b0 : cfg_frame_en;
  wire len_in   = frame_in | cfg_len_en;

  wire [7:1] en_in = {cfg_crc_en, cfg_crc_en, cfg_pay_len != 8'd0, len_in,
                      frame_in, frame_in, cfg_pre_units != '0};
  wire [7:1] en_q  = {crc_q, crc_q, plen_q != 8'd0, len_q,
                      frame_q, frame_q, pre_q != '0};

  wire [2:0] first_st = follow(en_in, S_IDLE);
  wire [2:0] next_st  = follow(en_q, state);
  wire       hs       = out_valid && out_ready;
  wire       unit_end = (state == S_PRE) ? (cnt == 8'(pre_q) - 8'd1)
                                         : (cnt == plen_q - 8'd1);
  wire       repeat_f = (state == S_PRE || state == S_PAY) && !unit_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      crc     <= '0;
      mode_q  <= '0;
      frame_q <= 1'b0;
      len_q   <= 1'b0;
      crc_q   <= 1'b0;
      long_q  <= 1'b0;
      pre_q   <= '0;
      plen_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          mode_q  <= cfg_mode;
          frame_q <= frame_in;
          len_q   <= len_in;
          crc_q   <= cfg_crc_en;
          long_q  <= cfg_sym_long;
          pre_q   <= cfg_pre_units;
          plen_q  <= cfg_pay_len;
          crc     <= cfg_crc_zero_seed ? 16'h0000 : cfg_crc_seed;
          cnt     <= '0;
          state   <= first_st;
          if (first_st == S_IDLE) done <= 1'b1;
        end
      end else if (hs) begin
        if (state == S_PAY) crc <= crc_step(crc, in_data);
        if (repeat_f) begin
          cnt <= cnt + 8'd1;
        end else begin
          cnt   <= '0;
          state <= next_st;
          if (next_st == S_IDLE) done <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (state)
      S_PRE:   out_data = cnt;
      S_FR1:   out_data = 8'd0;
      S_FR2:   out_data = 8'd1;
      S_LEN:   out_data = plen_q;
      S_PAY:   out_data = in_data;
      S_CRH:   out_data = crc[15:8];
      S_CRL:   out_data = crc[7:0];
      default: out_data = 8'd0;
    endcase
  end

  assign busy      = state != S_IDLE;
  assign out_field = state;
  assign out_valid = (state == S_PAY) ? in_valid : busy;
  assign in_ready  = (state == S_PAY) && out_ready;
  assign out_code  = (state == S_FR1) || (state == S_FR2);
  assign out_long  = out_code && long_q;
  assign out_rate  = mode_q;
endmodule

module tx_pkt_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic [7:0] out_data,
  input logic [2:0] out_field,
  input logic       out_code,
  input logic [1:0] out_rate,
  input logic       out_valid,
  input logic       out_ready,
  input logic       busy,
  input logic       done
);
  // R6
  pay_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_field == 3'd5);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && out_field != 3'd5) |=>
      (out_valid && $stable(out_data) && $stable(out_field)));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  frame_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_code) |-> (out_field == 3'd2 || out_field == 3'd3));

  // R4
  sdr_noframe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_rate == 2'd3) |-> !out_code);

  // R2
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!busy || out_field >= $past(out_field)));
endmodule

bind tx_pkt_seq tx_pkt_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_data(out_data),
  .out_field(out_field), .out_code(out_code), .out_rate(out_rate),
  .out_valid(out_valid), .out_ready(out_ready), .busy(busy), .done(done)
);

// File: tb/tx_pkt_seq_test.sv
module tx_pkt_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] cfg_mode = '0;
  logic cfg_frame_en = 1'b0, cfg_len_en = 1'b0, cfg_crc_en = 1'b0;
  logic cfg_crc_zero_seed = 1'b0, cfg_sym_long = 1'b0;
  logic [3:0] cfg_pre_units = '0;
  logic [7:0] cfg_pay_len = '0;
  logic [15:0] cfg_crc_seed = '0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] out_data;
  logic [2:0] out_field;
  logic out_code, out_long, out_valid, busy, done;
  logic [1:0] out_rate;
  logic out_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  tx_pkt_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
    .cfg_frame_en(cfg_frame_en), .cfg_len_en(cfg_len_en), .cfg_crc_en(cfg_crc_en),
    .cfg_crc_zero_seed(cfg_crc_zero_seed), .cfg_sym_long(cfg_sym_long),
    .cfg_pre_units(cfg_pre_units), .cfg_pay_len(cfg_pay_len), .cfg_crc_seed(cfg_crc_seed),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_field(out_field), .out_code(out_code),
    .out_long(out_long), .out_rate(out_rate), .out_valid(out_valid),
    .out_ready(out_ready), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ b[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h8005;
    end
    return r;
  endfunction

  function automatic string req_of(input int f);
    case (f)
      1: return "R3";
      2, 3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run_packet(input int pkt, input int mode, input bit fr_en, input bit ln_en,
                            input bit cr_en, input int pre, input int plen);
    int ef[64], ed[64], ec[64], el[64];
    logic [7:0] pay[8];
    int n = 0, k = 0, pidx = 0, prevf = 0, prevd = 0;
    bit stalled = 0, fr, ln, zs, lg;
    logic [15:0] seed, c;
    zs = pkt[0];
    lg = pkt[1];
    seed = 16'(pkt * 1234 + 77);
    fr = (mode < 2) ? 1'b1 : (mode == 3) ? 1'b0 : fr_en;
    ln = fr | ln_en;
    for (int i = 0; i < plen; i++) pay[i] = 8'((pkt * 37 + i * 11 + 5) & 255);
    for (int j = 0; j < pre; j++) begin ef[n] = 1; ed[n] = j; ec[n] = 0; el[n] = 0; n++; end
    if (fr) begin
      ef[n] = 2; ed[n] = 0; ec[n] = 1; el[n] = lg; n++;
      ef[n] = 3; ed[n] = 1; ec[n] = 1; el[n] = lg; n++;
    end
    if (ln) begin ef[n] = 4; ed[n] = plen; ec[n] = 0; el[n] = 0; n++; end
    c = zs ? 16'h0 : seed;
    for (int i = 0; i < plen; i++) begin
      ef[n] = 5; ed[n] = pay[i]; ec[n] = 0; el[n] = 0; n++;
      c = ref_crc(c, pay[i]);
    end
    if (cr_en) begin
      ef[n] = 6; ed[n] = c[15:8]; ec[n] = 0; el[n] = 0; n++;
      ef[n] = 7; ed[n] = c[7:0]; ec[n] = 0; el[n] = 0; n++;
    end

    @(negedge clk);
    cfg_mode = 2'(mode); cfg_frame_en = fr_en; cfg_len_en = ln_en; cfg_crc_en = cr_en;
    cfg_crc_zero_seed = zs; cfg_sym_long = lg; cfg_pre_units = 4'(pre);
    cfg_pay_len = 8'(plen); cfg_crc_seed = seed; start = 1'b1;
    #1 chk(!busy, "R10", "busy before start", busy, 0);
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    // R11: scramble configuration during the packet
    cfg_mode = ~cfg_mode; cfg_frame_en = ~fr_en; cfg_len_en = ~ln_en; cfg_crc_en = ~cr_en;
    cfg_crc_zero_seed = ~zs; cfg_sym_long = ~lg; cfg_pre_units = ~cfg_pre_units;
    cfg_pay_len = 8'd200; cfg_crc_seed = ~seed;
    while (k < n) begin
      cyc++;
      out_ready = ((cyc * 7 + pkt) % 5) != 0;
      in_valid  = (cyc % 3) != 1;
      in_data   = (pidx < plen) ? pay[pidx] : 8'hEE;
      start     = (k == 1);
      #1;
      chk(busy && !done, "R10", "busy/done mid packet", {busy, done}, 2);
      if (stalled && prevf != 5)
        chk(out_valid && out_field == 3'(prevf) && out_data == 8'(prevd), "R9",
            "held item", out_data, prevd);
      if (out_valid && out_ready) begin
        chk(out_field == 3'(ef[k]), "R2", "field", out_field, ef[k]);
        chk(out_data == 8'(ed[k]), req_of(ef[k]), "data", out_data, ed[k]);
        chk(out_code == ec[k][0] && out_long == el[k][0] && out_rate == 2'(mode), "R8",
            "tags", {out_code, out_long, out_rate}, {ec[k][0], el[k][0], 2'(mode)});
        k++;
      end
      chk(in_ready == (out_field == 3'd5 && out_ready), "R6", "in_ready", in_ready,
          out_field == 3'd5 && out_ready);
      stalled = out_valid && !out_ready;
      prevf = out_field;
      prevd = out_data;
      if (in_valid && in_ready) pidx++;
      @(posedge clk); @(negedge clk);
    end
    start = 1'b0;
    #1 chk(done && !busy, "R10", "done after last item", {done, busy}, 2);
    chk(pidx == plen, "R6", "payload bytes taken", pidx, plen);
    @(posedge clk); @(negedge clk);
    #1 chk(!done && !busy && !out_valid, "R11", "no extra packet", {done, busy, out_valid}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pkt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 chk(!busy && !done && !out_valid && !in_ready, "R1", "reset state",
           {busy, done, out_valid, in_ready}, 0);
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++)
      for (int f = 0; f < 2; f++)
        for (int l = 0; l < 2; l++)
          for (int c = 0; c < 2; c++)
            for (int pi = 0; pi < 3; pi++)
              for (int li = 0; li < 3; li++) begin
                run_packet(pkt, m, f[0], l[0], c[0], (pi == 0) ? 0 : (pi == 1) ? 2 : 15,
                           (li == 0) ? 0 : (li == 1) ? 1 : 5);
                pkt++;
              end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule